// File: doc/BRIEF.md
# Data Phase Byte Counter

This block follows the progress of a data phase on a SCSI-style bus. It keeps a 24-bit count of bytes still to move, which counts down, and a 32-bit bus-side address, which counts up. Software loads both a byte at a time through a small 8-bit register port. The count and the address move only when the handshake logic outside the block reports, on `xfer_ok_i`, that one byte has been fully and safely transferred. A strobe that only marks the start of a transfer must not be sent here.

Two sticky events are recorded. The first is done: a confirmed byte brought the count to zero. The second is wrap: a confirmed byte arrived while the count was already zero, so the count rolled over to 0xFFFFFF. Software reads both events at one status address. Writing a one to a bit at that same address clears the matching event. A per-event enable mask selects which events drive the single interrupt output.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset the count, the address, both event flags and the enable mask are zero, and `irq_o` is low.
- R2: The count is read and written as bytes at offsets 0x0 (bits 7:0), 0x1 (bits 15:8) and 0x2 (bits 23:16). A write changes only the byte it addresses.
- R3: The address is read and written as bytes at offsets 0x4 (bits 7:0) through 0x7 (bits 31:24). A write changes only the byte it addresses.
- R4: Each clock edge with `xfer_ok_i` high lowers the count by one and raises the address by one. Both new values are visible after that edge. Without the strobe, neither value moves.
- R5: A confirmed byte that takes the count from 1 to 0 sets the done flag, which is status bit 0 at offset 0x8.
- R6: A confirmed byte that arrives while the count is 0 sets the count to 0xFFFFFF and sets the wrap flag, which is status bit 1. It does not set the done flag.
- R7: The address rolls from 0xFFFFFFFF to 0x00000000 without raising any flag.
- R8: Offset 0x8 returns {6'b0, wrap, done}. Writing it clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R9: Writing offset 0x3 with data bit 0 set clears the count and leaves the address unchanged. Offset 0x3 always reads 0.
- R10: When a count clear and `xfer_ok_i` fall in the same cycle, the count ends at 0, neither flag is set, and the address still advances by one.
- R11: When a flag's set event and a write-one clear of that same flag fall in the same cycle, the flag ends set.
- R12: Offset 0x9 holds the enable mask: bit 0 enables done and bit 1 enables wrap. `irq_o` is high exactly when some flag is set and its enable bit is 1.
- R13: A byte write to the count or the address in the same cycle as `xfer_ok_i` takes effect as written, and that register ignores the strobe for that cycle. The other register still steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register offset |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from `reg_addr_i` |
| xfer_ok_i | input | 1 | One byte confirmed transferred (one per cycle) |
| irq_o | output | 1 | OR of the enabled sticky flags |

## Verification
Register writes and the transfer strobe are independent, so several pairs can land on the same clock edge. The count clear can meet a strobe at zero count. A write-one clear of done can meet the decrement from 1 to 0. A byte load of either counter can meet a strobe. The bench drives each pair on the same falling edge so that both act at one rising edge. It then reads back the count, the address and the status. The results must match the stated priorities: a clear or load wins over the step for its own register, and a new event wins over its own clear.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;
  localparam int CNT_W   = 24;
  localparam int ADR_W   = 32;
  localparam int REG_AW  = 4;
  localparam int NFLAG   = 2;
  localparam int CNT_NB  = CNT_W / 8;
  localparam int ADR_NB  = ADR_W / 8;

  localparam logic [REG_AW-1:0] OFS_CNT0 = 4'h0;
  localparam logic [REG_AW-1:0] OFS_CTRL = 4'h3;
  localparam logic [REG_AW-1:0] OFS_ADR0 = 4'h4;
  localparam logic [REG_AW-1:0] OFS_STAT = 4'h8;
  localparam logic [REG_AW-1:0] OFS_MASK = 4'h9;

  localparam int FLG_DONE = 0;
  localparam int FLG_WRAP = 1;
  localparam int CTRL_CLR_BIT = 0;
endpackage

// File: rtl/xfer_step_cnt.sv
module xfer_step_cnt #(
  parameter int WIDTH = 24,
  parameter bit DOWN  = 1'b1,
  localparam int NB   = WIDTH / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [NB-1:0]    byte_we_i,
  input  logic [7:0]       wdata_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] value_o
);
  logic [WIDTH-1:0] value_q, loaded, stepped;

  generate
    if (DOWN) begin : g_down
      assign stepped = value_q - WIDTH'(1);
    end else begin : g_up
      assign stepped = value_q + WIDTH'(1);
    end
  endgenerate

  always_comb begin
    loaded = value_q;
    for (int b = 0; b < NB; b++) begin
      if (byte_we_i[b]) loaded[b*8 +: 8] = wdata_i;
    end
  end

  // clear > byte load > step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            value_q <= '0;
    else if (clear_i)       value_q <= '0;
    else if (|byte_we_i)    value_q <= loaded;
    else if (step_i)        value_q <= stepped;
  end

  assign value_o = value_q;
endmodule

// File: rtl/xfer_flags.sv
module xfer_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic             mask_we_i,
  input  logic [NFLAG-1:0] mask_d_i,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] mask_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flags_q, mask_q;

  // set wins over write-one clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & mask_q);
endmodule

// File: rtl/xfer_regif.sv
module xfer_regif
  import xfer_cnt_pkg::*;
(
  input  logic [REG_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADR_W-1:0]  adr_i,
  input  logic [NFLAG-1:0]  flags_i,
  input  logic [NFLAG-1:0]  mask_i,
  output logic [CNT_NB-1:0] cnt_we_o,
  output logic [ADR_NB-1:0] adr_we_o,
  output logic              ctrl_we_o,
  output logic              stat_we_o,
  output logic              mask_we_o,
  output logic [7:0]        rdata_o
);
  genvar b;
  generate
    for (b = 0; b < CNT_NB; b++) begin : g_cnt_dec
      assign cnt_we_o[b] = we_i && (addr_i == OFS_CNT0 + REG_AW'(b));
    end
    for (b = 0; b < ADR_NB; b++) begin : g_adr_dec
      assign adr_we_o[b] = we_i && (addr_i == OFS_ADR0 + REG_AW'(b));
    end
  endgenerate

  assign ctrl_we_o = we_i && (addr_i == OFS_CTRL);
  assign stat_we_o = we_i && (addr_i == OFS_STAT);
  assign mask_we_o = we_i && (addr_i == OFS_MASK);

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < CNT_NB; i++) begin
      if (addr_i == OFS_CNT0 + REG_AW'(i)) rdata_o = cnt_i[i*8 +: 8];
    end
    for (int i = 0; i < ADR_NB; i++) begin
      if (addr_i == OFS_ADR0 + REG_AW'(i)) rdata_o = adr_i[i*8 +: 8];
    end
    if (addr_i == OFS_STAT) rdata_o = 8'(flags_i);
    if (addr_i == OFS_MASK) rdata_o = 8'(mask_i);
  end
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
  import xfer_cnt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              xfer_ok_i,
  output logic              irq_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [ADR_W-1:0]  adr_q;
  logic [NFLAG-1:0]  flags_q, mask_q, flag_set, flag_clr;
  logic [CNT_NB-1:0] cnt_we;
  logic [ADR_NB-1:0] adr_we;
  logic              ctrl_we, stat_we, mask_we, cnt_clr, cnt_step;

  xfer_regif u_regif (
    .addr_i    (reg_addr_i),
    .we_i      (reg_we_i),
    .cnt_i     (cnt_q),
    .adr_i     (adr_q),
    .flags_i   (flags_q),
    .mask_i    (mask_q),
    .cnt_we_o  (cnt_we),
    .adr_we_o  (adr_we),
    .ctrl_we_o (ctrl_we),
    .stat_we_o (stat_we),
    .mask_we_o (mask_we),
    .rdata_o   (reg_rdata_o)
  );

  assign cnt_clr  = ctrl_we && reg_wdata_i[CTRL_CLR_BIT];
  // step actually applied to the count
  assign cnt_step = xfer_ok_i && !cnt_clr && !(|cnt_we);

  xfer_step_cnt #(.WIDTH(CNT_W), .DOWN(1'b1)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (cnt_clr),
    .byte_we_i (cnt_we),
    .wdata_i   (reg_wdata_i),
    .step_i    (xfer_ok_i),
    .value_o   (cnt_q)
  );

  xfer_step_cnt #(.WIDTH(ADR_W), .DOWN(1'b0)) u_adr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (1'b0),
    .byte_we_i (adr_we),
    .wdata_i   (reg_wdata_i),
    .step_i    (xfer_ok_i),
    .value_o   (adr_q)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_DONE] = cnt_step && (cnt_q == CNT_W'(1));
    flag_set[FLG_WRAP] = cnt_step && (cnt_q == '0);
  end

  assign flag_clr = stat_we ? reg_wdata_i[NFLAG-1:0] : '0;

  xfer_flags #(.NFLAG(NFLAG)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (flag_set),
    .clr_i     (flag_clr),
    .mask_we_i (mask_we),
    .mask_d_i  (reg_wdata_i[NFLAG-1:0]),
    .flags_o   (flags_q),
    .mask_o    (mask_q),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/xfer_count_unit_chk.sv
module xfer_count_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  reg_addr_i,
  input logic        reg_we_i,
  input logic [7:0]  reg_wdata_i,
  input logic        xfer_ok_i,
  input logic        irq_o,
  input logic [23:0] cnt_q,
  input logic [31:0] adr_q,
  input logic [1:0]  flags_q
);
  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ok_i && !reg_we_i |=> cnt_q == 24'($past(cnt_q) - 24'd1));

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ok_i && !reg_we_i |=> adr_q == 32'($past(adr_q) + 32'd1));

  assert_count_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_ok_i && !reg_we_i |=> $stable(cnt_q) && $stable(adr_q));

  assert_done_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ok_i && !reg_we_i && cnt_q == 24'd1 |=> flags_q[0]);

  assert_wrap_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ok_i && !reg_we_i && cnt_q == 24'd0 |=> flags_q[1] && cnt_q == 24'hFFFFFF);

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q[0] && !(reg_we_i && reg_addr_i == 4'h8 && reg_wdata_i[0]) |=> flags_q[0]);

  assert_done_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 4'h8 && reg_wdata_i[0] && !xfer_ok_i |=> !flags_q[0]);

  assert_clr_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 4'h3 && reg_wdata_i[0] |=> cnt_q == 24'd0);

  assert_irq_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q == 2'b00 |-> !irq_o);
endmodule

bind xfer_count_unit xfer_count_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .xfer_ok_i   (xfer_ok_i),
  .irq_o       (irq_o),
  .cnt_q       (cnt_q),
  .adr_q       (adr_q),
  .flags_q     (flags_q)
);

// File: tb/xfer_count_unit_bench.sv
module xfer_count_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       xfer_ok_i = 1'b0;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  xfer_count_unit u_xfer_count_unit (.*);

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // write and strobe on the same edge
  task automatic wr_strobe(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1; xfer_ok_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; xfer_ok_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      xfer_ok_i = 1'b1;
    end
    @(negedge clk_i);
    xfer_ok_i = 1'b0;
  endtask

  task automatic set_cnt(logic [23:0] v);
    for (int i = 0; i < 3; i++) wr(4'(i), v[i*8 +: 8]);
  endtask

  task automatic set_adr(logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(4'(4 + i), v[i*8 +: 8]);
  endtask

  task automatic get_cnt(output logic [23:0] v);
    logic [7:0] b;
    for (int i = 0; i < 3; i++) begin rd(4'(i), b); v[i*8 +: 8] = b; end
  endtask

  task automatic get_adr(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(4'(4 + i), b); v[i*8 +: 8] = b; end
  endtask

  task automatic get_stat(output logic [7:0] v);
    rd(4'h8, v);
  endtask

  task automatic t_reset;
    logic [23:0] c; logic [31:0] a; logic [7:0] s, m;
    get_cnt(c); get_adr(a); get_stat(s); rd(4'h9, m);
    chk("R1", "count", 32'(c), 0);
    chk("R1", "address", a, 0);
    chk("R1", "status", 32'(s), 0);
    chk("R1", "mask", 32'(m), 0);
    chk("R1", "irq", 32'(irq_o), 0);
  endtask

  task automatic t_load;
    logic [23:0] c; logic [31:0] a;
    set_cnt(24'h123456); get_cnt(c);
    chk("R2", "count bytes", 32'(c), 32'h123456);
    wr(4'h1, 8'hAB); get_cnt(c);
    chk("R2", "single byte write", 32'(c), 32'h12AB56);
    set_adr(32'hDEADBEEF); get_adr(a);
    chk("R3", "address bytes", a, 32'hDEADBEEF);
    wr(4'h7, 8'h01); get_adr(a);
    chk("R3", "top byte write", a, 32'h01ADBEEF);
  endtask

  task automatic t_step;
    logic [23:0] c; logic [31:0] a;
    set_cnt(24'h123456); set_adr(32'h0000_1000);
    pulse(3); get_cnt(c); get_adr(a);
    chk("R4", "count after 3", 32'(c), 32'h123453);
    chk("R4", "address after 3", a, 32'h1003);
    repeat (5) @(negedge clk_i);
    get_cnt(c); get_adr(a);
    chk("R4", "count idle", 32'(c), 32'h123453);
    chk("R4", "address idle", a, 32'h1003);
  endtask

  task automatic t_done;
    logic [23:0] c; logic [7:0] s;
    wr(4'h8, 8'h03);
    set_cnt(24'd2); pulse(2); get_cnt(c); get_stat(s);
    chk("R5", "count", 32'(c), 0);
    chk("R5", "status done only", 32'(s), 32'h01);
    chk("R12", "irq masked", 32'(irq_o), 0);
    wr(4'h9, 8'h01);
    chk("R12", "irq enabled", 32'(irq_o), 1);
    wr(4'h8, 8'h02); get_stat(s);
    chk("R8", "write 0 keeps done", 32'(s), 32'h01);
    wr(4'h8, 8'h01); get_stat(s);
    chk("R8", "w1c done", 32'(s), 0);
    chk("R12", "irq after clear", 32'(irq_o), 0);
  endtask

  task automatic t_wrap;
    logic [23:0] c; logic [7:0] s;
    wr(4'h9, 8'h02);
    set_cnt(24'd0); pulse(1); get_cnt(c); get_stat(s);
    chk("R6", "count wraps", 32'(c), 32'hFFFFFF);
    chk("R6", "wrap flag only", 32'(s), 32'h02);
    chk("R12", "irq on wrap", 32'(irq_o), 1);
    wr(4'h8, 8'h02); get_stat(s);
    chk("R8", "w1c wrap", 32'(s), 0);
    wr(4'h9, 8'h00);
  endtask

  task automatic t_addr_wrap;
    logic [31:0] a; logic [7:0] s;
    set_cnt(24'h000100); set_adr(32'hFFFFFFFF);
    pulse(1); get_adr(a); get_stat(s);
    chk("R7", "address rolls", a, 0);
    chk("R7", "no flag", 32'(s), 0);
  endtask

  task automatic t_clear;
    logic [23:0] c; logic [31:0] a; logic [7:0] r;
    set_cnt(24'h000500); set_adr(32'h0000_2000);
    wr(4'h3, 8'h01); get_cnt(c); get_adr(a); rd(4'h3, r);
    chk("R9", "count cleared", 32'(c), 0);
    chk("R9", "address kept", a, 32'h2000);
    chk("R9", "ctrl reads 0", 32'(r), 0);
  endtask

  task automatic t_clr_vs_strobe;
    logic [23:0] c; logic [31:0] a; logic [7:0] s;
    wr(4'h8, 8'h03);
    set_cnt(24'd0); set_adr(32'h0000_3000);
    wr_strobe(4'h3, 8'h01); get_cnt(c); get_adr(a); get_stat(s);
    chk("R10", "count stays 0", 32'(c), 0);
    chk("R10", "no flag", 32'(s), 0);
    chk("R10", "address steps", a, 32'h3001);
  endtask

  task automatic t_set_vs_w1c;
    logic [23:0] c; logic [7:0] s;
    set_cnt(24'd1); pulse(1); get_stat(s);
    chk("R5", "done before race", 32'(s), 32'h01);
    set_cnt(24'd1);
    wr_strobe(4'h8, 8'h01); get_cnt(c); get_stat(s);
    chk("R11", "set wins over clear", 32'(s), 32'h01);
    chk("R11", "count reached 0", 32'(c), 0);
    wr(4'h8, 8'h03);
  endtask

  task automatic t_write_vs_strobe;
    logic [23:0] c; logic [31:0] a;
    set_cnt(24'h000010); set_adr(32'h0000_4000);
    wr_strobe(4'h0, 8'h80); get_cnt(c); get_adr(a);
    chk("R13", "count load wins", 32'(c), 32'h80);
    chk("R13", "address still steps", a, 32'h4001);
    wr_strobe(4'h4, 8'h55); get_cnt(c); get_adr(a);
    chk("R13", "address load wins", a, 32'h4055);
    chk("R13", "count still steps", 32'(c), 32'h7F);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_step();
    t_done();
    t_wrap();
    t_addr_wrap();
    t_clear();
    t_clr_vs_strobe();
    t_set_vs_w1c();
    t_write_vs_strobe();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule